// File: doc/BRIEF.md
# Eight-Bit Universal Shift Register on a Shared Bus

The block is an eight-bit register updated on the rising clock edge. A two-bit select picks one of four modes: hold, shift toward the high end, shift toward the low end, and parallel load. The parallel bus is shared. It carries data into the register during a load. At all other times it can drive the register contents back out. The bus is modelled as three separate vectors: an input vector, an output data vector and a per-bit output-enable vector. A pad-level wrapper can join these into one bidirectional pin set.

Two active-low enables gate the bus drivers. Neither enable changes what the register does. The two end bits of the register are always presented on dedicated serial outputs. An active-low clear empties the register at once, without waiting for a clock. Its release is synchronised to the clock, so the register leaves the cleared state only on a whole clock cycle.

Top module: `usr_shift8`

## Requirements
- R1: With sel = 2'b00 (hold), a rising edge leaves the register unchanged, whatever values bus_in, sr_in and sl_in carry.
- R2: With sel = 2'b01 (shift right), a rising edge moves every bit one place toward bit 7. Bit 0 (position A) takes sr_in, and bit i takes the old bit i-1.
- R3: With sel = 2'b10 (shift left), a rising edge moves every bit one place toward bit 0. Bit 7 (position H) takes sl_in, and bit i takes the old bit i+1.
- R4: With sel = 2'b11 (load), a rising edge copies bus_in into the register, and bus_oe is all zeros while sel = 2'b11.
- R5: bus_oe is all ones only when oe1_n and oe2_n are both 0 and sel is not 2'b11. Otherwise it is all zeros. bus_out always equals the register contents. The enables have no effect on hold, shift or load.
- R6: While clr_n is 0, the register, bus_out, qa_ser and qh_ser are all 0. They go to 0 as soon as clr_n falls, without a clock edge.
- R7: After clr_n rises, the register stays 0 through the next two rising edges, whatever the mode. The selected mode first acts on the third rising edge.
- R8: qa_ser always equals register bit 0 and qh_ser always equals register bit 7, whatever the enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register updates on the rising edge |
| clr_n | input | 1 | Active-low clear; asserts at once, releases in step with the clock |
| sel | input | 2 | Mode: 00 hold, 01 shift right, 10 shift left, 11 load |
| oe1_n | input | 1 | First active-low bus driver enable |
| oe2_n | input | 1 | Second active-low bus driver enable |
| sr_in | input | 1 | Serial bit entering bit 0 on a right shift |
| sl_in | input | 1 | Serial bit entering bit 7 on a left shift |
| bus_in | input | 8 | Levels seen on the shared bus pins |
| bus_out | output | 8 | Register contents offered to the bus drivers |
| bus_oe | output | 8 | Per-bit driver enable for the bus; 0 means high impedance |
| qa_ser | output | 1 | Serial output from bit 0 |
| qh_ser | output | 1 | Serial output from bit 7 |

## Verification
The register contents, and with them bus_out, qa_ser and qh_ser, are due one rising edge after the inputs that select a mode. bus_oe follows sel and the enables within the same cycle. Clear takes effect with no edge at all, and the mode is ignored for two edges after clear is released. The driver applies inputs on the falling edge and queues the state it expects after the next rising edge. The monitor samples a quarter period after that rising edge, when both the registered state and the combinational enable have settled. The asynchronous clear is checked one nanosecond after clr_n falls, part-way between edges, with no edge in between.

// File: rtl/usr_pkg.sv
// Package: shared mode encoding for the universal shift register.
// Assumes a two-bit select; the encoding is fixed because it is decoded
// directly from the select pins.
package usr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD  = 2'b00,
        MODE_SHR   = 2'b01,
        MODE_SHL   = 2'b10,
        MODE_LOAD  = 2'b11
    } usr_mode_e;

endpackage

// File: rtl/usr_clr_sync.sv
// Clear synchroniser: asserts the internal reset as soon as clr_n falls,
// and releases it only after STAGES rising edges with clr_n high.
// Assumes clr_n may change at any time relative to clk.
module usr_clr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr_n,
    output logic rst_n
);

    logic [STAGES-1:0] stg;

    // Shift ones in after release; clear all stages at once on assertion.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            stg <= '0;
        end else begin
            stg <= {stg[STAGES-2:0], 1'b1};
        end
    end

    assign rst_n = stg[STAGES-1];

endmodule

// File: rtl/usr_next_state.sv
// Next-state logic: builds the register's next value bit by bit from the
// mode, both neighbours, the serial inputs and the bus input.
// Assumes bit 0 is the low end that takes sr_in on a right shift.
module usr_next_state
    import usr_pkg::*;
#(
    parameter int W = 8
) (
    input  usr_mode_e      mode,
    input  logic [W-1:0]   q,
    input  logic [W-1:0]   bus_in,
    input  logic           sr_in,
    input  logic           sl_in,
    output logic [W-1:0]   d
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic lower;
        logic upper;

        if (i == 0) begin : g_lo_end
            assign lower = sr_in;
        end else begin : g_lo_mid
            assign lower = q[i-1];
        end

        if (i == W - 1) begin : g_hi_end
            assign upper = sl_in;
        end else begin : g_hi_mid
            assign upper = q[i+1];
        end

        // Per-bit four-way mode multiplexer.
        always_comb begin
            unique case (mode)
                MODE_HOLD: d[i] = q[i];
                MODE_SHR:  d[i] = lower;
                MODE_SHL:  d[i] = upper;
                MODE_LOAD: d[i] = bus_in[i];
                default:   d[i] = q[i];
            endcase
        end
    end

endmodule

// File: rtl/usr_bus_ctrl.sv
// Bus driver control: enables the bus drivers only when both active-low
// enables are low and the block is not loading from the bus.
// Assumes the drivers are controlled per bit by one common enable.
module usr_bus_ctrl
    import usr_pkg::*;
#(
    parameter int W = 8
) (
    input  usr_mode_e    mode,
    input  logic         oe1_n,
    input  logic         oe2_n,
    output logic [W-1:0] oe
);

    logic drive;

    // Decide whether the shared bus is driven in this cycle.
    always_comb begin
        drive = !oe1_n && !oe2_n && (mode != MODE_LOAD);
    end

    for (genvar i = 0; i < W; i++) begin : g_oe
        assign oe[i] = drive;
    end

endmodule

// File: rtl/usr_shift8.sv
// Universal shift register on a shared bus: hold, shift right, shift left
// or load on each rising edge. Clear empties it at once and releases it in
// step with the clock. Assumes the bus is split into in, out and enable
// vectors and that any pad wrapper sits outside this block.
module usr_shift8
    import usr_pkg::*;
#(
    parameter int W        = 8,
    parameter int CLR_SYNC = 2
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [1:0]   sel,
    input  logic         oe1_n,
    input  logic         oe2_n,
    input  logic         sr_in,
    input  logic         sl_in,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] bus_out,
    output logic [W-1:0] bus_oe,
    output logic         qa_ser,
    output logic         qh_ser
);

    usr_mode_e    mode;
    logic         rst_n_int;
    logic [W-1:0] q;
    logic [W-1:0] d;

    // Map the select pins onto the mode type.
    always_comb begin
        mode = usr_mode_e'(sel);
    end

    usr_clr_sync #(.STAGES(CLR_SYNC)) u_sync (
        .clk   (clk),
        .clr_n (clr_n),
        .rst_n (rst_n_int)
    );

    usr_next_state #(.W(W)) u_next (
        .mode   (mode),
        .q      (q),
        .bus_in (bus_in),
        .sr_in  (sr_in),
        .sl_in  (sl_in),
        .d      (d)
    );

    usr_bus_ctrl #(.W(W)) u_bus (
        .mode  (mode),
        .oe1_n (oe1_n),
        .oe2_n (oe2_n),
        .oe    (bus_oe)
    );

    // Register storage: clears at once, updates on the rising edge.
    always_ff @(posedge clk or negedge rst_n_int) begin
        if (!rst_n_int) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign bus_out = q;
    assign qa_ser  = q[0];
    assign qh_ser  = q[W-1];

endmodule

// File: rtl/usr_shift8_chk.sv
// Checker for usr_shift8: relates the ports and the synchronised reset
// over time. Attached to every instance of the top through bind.
module usr_shift8_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         clr_n,
    input logic         rst_q,
    input logic [1:0]   sel,
    input logic         oe1_n,
    input logic         oe2_n,
    input logic         sr_in,
    input logic         sl_in,
    input logic [W-1:0] bus_in,
    input logic [W-1:0] bus_out,
    input logic [W-1:0] bus_oe,
    input logic         qa_ser,
    input logic         qh_ser
);

    a_r1_hold: assert property (@(posedge clk) disable iff (!clr_n)
        (rst_q && sel == 2'b00) |=> $stable(bus_out));

    a_r2_shift_right: assert property (@(posedge clk) disable iff (!clr_n)
        (rst_q && sel == 2'b01) |=>
        bus_out == {$past(bus_out[W-2:0]), $past(sr_in)});

    a_r3_shift_left: assert property (@(posedge clk) disable iff (!clr_n)
        (rst_q && sel == 2'b10) |=>
        bus_out == {$past(sl_in), $past(bus_out[W-1:1])});

    a_r4_load: assert property (@(posedge clk) disable iff (!clr_n)
        (rst_q && sel == 2'b11) |=> bus_out == $past(bus_in));

    a_r4_load_floats: assert property (@(posedge clk)
        (sel == 2'b11) |-> bus_oe == '0);

    a_r5_enable_floats: assert property (@(posedge clk)
        (oe1_n || oe2_n) |-> bus_oe == '0);

    a_r5_enable_drives: assert property (@(posedge clk)
        (!oe1_n && !oe2_n && sel != 2'b11) |-> bus_oe == '1);

    a_r6_clear: assert property (@(posedge clk)
        !clr_n |-> (bus_out == '0 && !qa_ser && !qh_ser));

    a_r7_release: assert property (@(posedge clk) disable iff (!clr_n)
        !rst_q |=> bus_out == '0);

    a_r8_serial: assert property (@(posedge clk)
        qa_ser == bus_out[0] && qh_ser == bus_out[W-1]);

endmodule

bind usr_shift8 usr_shift8_chk #(.W(W)) u_chk (
    .clk     (clk),
    .clr_n   (clr_n),
    .rst_q   (rst_n_int),
    .sel     (sel),
    .oe1_n   (oe1_n),
    .oe2_n   (oe2_n),
    .sr_in   (sr_in),
    .sl_in   (sl_in),
    .bus_in  (bus_in),
    .bus_out (bus_out),
    .bus_oe  (bus_oe),
    .qa_ser  (qa_ser),
    .qh_ser  (qh_ser)
);

// File: tb/sim_usr_shift8.sv
module sim_usr_shift8;

    localparam int CLK_NS = 10;
    localparam int W      = 8;

    typedef struct {
        logic [W-1:0] q;
        logic [W-1:0] oe;
        string        tag;
    } exp_t;

    logic         clk = 0;
    logic         clr_n = 0;
    logic [1:0]   sel = 2'b00;
    logic         oe1_n = 0;
    logic         oe2_n = 0;
    logic         sr_in = 0;
    logic         sl_in = 0;
    logic [W-1:0] bus_in = '0;
    logic [W-1:0] bus_out;
    logic [W-1:0] bus_oe;
    logic         qa_ser;
    logic         qh_ser;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;
    exp_t sb[$];

    logic [W-1:0] mq = '0;
    int           rel_cnt = 2;

    usr_shift8 u0 (
        .clk(clk), .clr_n(clr_n), .sel(sel), .oe1_n(oe1_n), .oe2_n(oe2_n),
        .sr_in(sr_in), .sl_in(sl_in), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .qa_ser(qa_ser), .qh_ser(qh_ser)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: apply inputs on the falling edge, queue the expected state.
    task automatic step(logic c, logic [1:0] s, logic r, logic l,
                        logic [W-1:0] b, logic e1, logic e2, string tag);
        exp_t it;
        @(negedge clk);
        clr_n = c; sel = s; sr_in = r; sl_in = l; bus_in = b;
        oe1_n = e1; oe2_n = e2;
        if (!c) begin
            mq = '0;
            rel_cnt = 2;
        end else if (rel_cnt > 0) begin
            rel_cnt--;
        end else begin
            case (s)
                2'b00: mq = mq;
                2'b01: mq = {mq[W-2:0], r};
                2'b10: mq = {l, mq[W-1:1]};
                default: mq = b;
            endcase
        end
        it.q   = mq;
        it.oe  = (!e1 && !e2 && s != 2'b11) ? '1 : '0;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compare a quarter period after each rising edge.
    always @(posedge clk) begin
        #(CLK_NS/4);
        if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            check({it.tag, " bus_out"}, bus_out, it.q);
            check({it.tag, " bus_oe (R5)"}, bus_oe, it.oe);
            check({it.tag, " qa_ser (R8)"}, {{(W-1){1'b0}}, qa_ser},
                  {{(W-1){1'b0}}, it.q[0]});
            check({it.tag, " qh_ser (R8)"}, {{(W-1){1'b0}}, qh_ser},
                  {{(W-1){1'b0}}, it.q[W-1]});
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] rpat;
        logic [W-1:0] lpat;
        rpat = 8'h3A;
        lpat = 8'h96;

        // R6: reset state while clear is held low.
        #(CLK_NS/4);
        check("R6 reset bus_out", bus_out, '0);
        check("R6 reset qa/qh", {6'b0, qa_ser, qh_ser}, '0);
        step(0, 2'b00, 1, 1, 8'hFF, 0, 0, "R6 clear held");

        // R7: two ignored edges after release, then the load acts (R4).
        step(1, 2'b11, 0, 0, 8'hA5, 0, 0, "R7 release edge1");
        step(1, 2'b11, 0, 0, 8'hA5, 0, 0, "R7 release edge2");
        step(1, 2'b11, 0, 0, 8'hC5, 0, 0, "R4 load C5");

        // R2: shift a pattern right fully through.
        for (int i = 0; i < W; i++)
            step(1, 2'b01, rpat[i], 0, 8'h00, 0, 0, "R2 shift right");
        // R3: shift a pattern left fully through.
        for (int i = 0; i < W; i++)
            step(1, 2'b10, 1'b0, lpat[i], 8'hFF, 0, 0, "R3 shift left");

        // R1: hold ignores bus and serial inputs.
        step(1, 2'b00, 1, 1, 8'h5A, 0, 0, "R1 hold");
        step(1, 2'b00, 0, 0, 8'hFF, 0, 0, "R1 hold");

        // R5: each enable combination in hold, shift and load.
        for (int e = 0; e < 4; e++) begin
            step(1, 2'b00, 0, 0, 8'h33, e[0], e[1], "R5 hold enables");
            step(1, 2'b01, e[0], 0, 8'h33, e[0], e[1], "R5 shift enables");
            step(1, 2'b10, 0, e[1], 8'h33, e[0], e[1], "R5 shift-left enables");
            step(1, 2'b11, 0, 0, 8'h10 + 8'(e), e[0], e[1], "R4 load enables");
        end

        // R6: asynchronous clear between edges.
        step(1, 2'b11, 0, 0, 8'hE7, 0, 0, "R4 load E7");
        @(negedge clk);
        #(CLK_NS/8);
        clr_n = 0;
        #1;
        check("R6 async clear bus_out", bus_out, '0);
        check("R6 async clear qa/qh", {6'b0, qa_ser, qh_ser}, '0);
        step(0, 2'b01, 1, 0, 8'h00, 0, 0, "R6 clear held shift");
        step(0, 2'b11, 0, 0, 8'hFF, 1, 0, "R6 clear held load");

        // R7: release under shift mode.
        step(1, 2'b01, 1, 0, 8'h00, 0, 0, "R7 release shift edge1");
        step(1, 2'b01, 1, 0, 8'h00, 0, 0, "R7 release shift edge2");
        step(1, 2'b01, 1, 0, 8'h00, 0, 0, "R2 first shift after release");
        step(1, 2'b10, 0, 1, 8'h00, 1, 1, "R3 shift left floating bus");

        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule